// File: doc/BRIEF.md
# I2C Slave Register Access Engine

This block lets an I2C bus master read and write a byte-wide register space that lives outside the block. The master first sends the device address with the direction bit clear, followed by a pointer byte. It then either keeps sending data bytes, each of which is written to the pointed register, or issues a repeated start with the direction bit set and clocks data out. A read may also start straight from the device address with the direction bit set, in which case it begins at the current pointer. The block drives SDA only as an open-drain pull-down enable. Both bus lines are brought into the system clock domain through a synchronizer before any edge or bus condition is detected.

After each byte, the pointer either advances or stays where it is. It advances only while it lies inside one of the configured auto-increment spans, and once it passes the configured last address it returns to 0x00. The 7-bit device address is a fixed 6-bit prefix followed by one programmable bit. That bit is sampled from a pin at reset and again when a general-call latch command arrives. A general-call reset command also emits a one-cycle reset pulse for the register space. If a write sets a chosen bit of a chosen register, the bus interface switches off until the next hardware reset.

Top module: `i2c_regport_slave`

## Requirements
- R1: The first byte after a start or repeated start is acknowledged (SDA pulled low during the ninth SCL pulse) only when its upper seven bits, sent MSB first, equal {DEV_PREFIX, latched pin bit}, or when the whole byte is 0x00. Any other first byte gets no acknowledge, and the block then ignores the bus until the next start or stop.
- R2: In a write (first byte bit 0 = 0), the second byte loads the pointer. Each later byte is acknowledged and presented once on the register port: reg_wr_o is high for one cycle, reg_addr_o holds the pointer value, and reg_wdata_o holds the byte.
- R3: Once a data byte has been transferred (written, or read out and clocked through its ninth bit), a pointer inside an auto-increment span [RANGE_LO[i], RANGE_HI[i]] advances by one.
- R4: A pointer outside every auto-increment span stays unchanged, so successive bytes use the same register.
- R5: When the pointer is inside a span and equals LAST_ADDR, the next advance sets it to 0x00.
- R6: In a read (first byte bit 0 = 1), the block drives the byte at the pointer MSB first, starting at the falling SCL edge that ends the acknowledge. A master acknowledge on the ninth bit makes it send the byte at the next pointer.
- R7: A master non-acknowledge on the ninth bit of a read byte makes the block release SDA and return to idle. It drives nothing until the next start.
- R8: After a general call (0x00), a second byte of 0x04 is acknowledged and latches the pin into the programmable address bit. A second byte of 0x06 does the same, and also raises gc_reset_o for exactly one cycle and clears the pointer to 0x00. Any other second byte is not acknowledged and changes nothing.
- R9: A data byte written to SHDN_ADDR with bit SHDN_BIT set is acknowledged. From the falling SCL edge that ends that acknowledge, the block neither acknowledges nor writes anything until rst.
- R10: A stop at any point returns the block to idle. A start or repeated start in the middle of a byte discards the partial byte without writing it.
- R11: After reset, SDA is released, no strobes are active, the pointer is 0x00, and the programmable address bit equals the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| addr_pin_i | input | 1 | Source of the programmable address bit |
| reg_addr_o | output | ADDR_W | Register address (current pointer) |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rd_o | output | 1 | One-cycle strobe when a byte is fetched for reading |
| reg_rdata_i | input | 8 | Read data for reg_addr_o, combinational |
| gc_reset_o | output | 1 | One-cycle reset pulse from the general-call reset command |

## Verification
The bench uses the default parameters. With these, the auto-increment spans are 0x00–0x04 and 0x10–0x12 and the last address is 0x12, so a four-byte burst from 0x10 crosses the wrap to 0x00. Address 0x08 sits in the non-incrementing gap between the spans. The shutdown control is bit 6 of address 0x04, which is inside the low span, so random bursts have to mask that bit. The device address is 0x20 or 0x21, depending on the latched bit. A 32-cycle SCL period keeps the two-stage synchronizer delay well inside each SCL phase.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_PTR,
        ST_WDATA,
        ST_GCCMD,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_RNEXT,
        ST_SKIP
    } eng_state_e;

    typedef enum logic [1:0] {
        GC_IGNORE,
        GC_LATCH,
        GC_LATCH_RST
    } gc_kind_e;

    typedef struct packed {
        eng_state_e st;
        eng_state_e after;
        logic [3:0] bitcnt;
        logic [7:0] sh;
        logic       oe;
        logic       pbit;
        logic       pend;
        logic       shut;
    } eng_t;

    localparam logic [7:0] GC_BYTE         = 8'h00;
    localparam logic [7:0] GC_CMD_LATCH    = 8'h04;
    localparam logic [7:0] GC_CMD_LATCHRST = 8'h06;
    localparam logic [3:0] BITS_PER_BYTE   = 4'd8;

    function automatic gc_kind_e gc_decode(input logic [7:0] b);
        if (b == GC_CMD_LATCHRST) return GC_LATCH_RST;
        if (b == GC_CMD_LATCH)    return GC_LATCH;
        return GC_IGNORE;
    endfunction

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    localparam int unsigned LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain   <= '1;
                prev[g] <= 1'b1;
            end else begin
                chain   <= {chain[STAGES-2:0], raw[g]};
                prev[g] <= chain[STAGES-1];
            end
        end
        assign cur[g] = chain[STAGES-1];
    end

    logic scl_c, scl_p, sda_c, sda_p;
    assign scl_c = cur[1];
    assign scl_p = prev[1];
    assign sda_c = cur[0];
    assign sda_p = prev[0];

    assign sda_s     = sda_c;
    assign scl_rise  = scl_c && !scl_p;
    assign scl_fall  = !scl_c && scl_p;
    assign start_det = scl_c && scl_p && sda_p && !sda_c;
    assign stop_det  = scl_c && scl_p && !sda_p && sda_c;

endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr #(
    parameter int unsigned              ADDR_W    = 8,
    parameter int unsigned              N_RANGES  = 2,
    parameter logic [ADDR_W-1:0]        LAST_ADDR = 8'h12,
    parameter logic [N_RANGES*ADDR_W-1:0] RANGE_LO = {8'h10, 8'h00},
    parameter logic [N_RANGES*ADDR_W-1:0] RANGE_HI = {8'h12, 8'h04}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr
);
    logic [N_RANGES-1:0] hit_vec;
    logic                hit;

    for (genvar g = 0; g < N_RANGES; g++) begin : g_span
        logic [ADDR_W-1:0] lo, hi, off, span;
        assign lo   = RANGE_LO[g*ADDR_W +: ADDR_W];
        assign hi   = RANGE_HI[g*ADDR_W +: ADDR_W];
        assign off  = ptr - lo;
        assign span = hi - lo;
        assign hit_vec[g] = (off <= span);
    end

    assign hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (adv && hit) begin
            ptr <= (ptr == LAST_ADDR) ? '0 : ptr + 1'b1;
        end
    end

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (adv && hit && !load && !clr && ptr != LAST_ADDR) |=> ptr == $past(ptr) + 1'b1);
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (adv && !hit && !load && !clr) |=> $stable(ptr));
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && hit && !load && !clr && ptr == LAST_ADDR) |=> ptr == '0);

endmodule

// File: rtl/i2c_rp_fsm.sv
module i2c_rp_fsm
    import i2c_rp_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 8,
    parameter logic [5:0]        DEV_PREFIX = 6'b010000,
    parameter logic [ADDR_W-1:0] SHDN_ADDR  = 8'h04,
    parameter int unsigned       SHDN_BIT   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic              addr_pin_i,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [7:0]        rdata,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              gc_rst,
    output logic              ptr_load,
    output logic              ptr_adv,
    output logic              ptr_clr,
    output logic [7:0]        shreg
);
    eng_t     q, d;
    logic     byte_done;
    gc_kind_e gk;

    assign byte_done = scl_fall && (q.bitcnt == BITS_PER_BYTE);
    assign gk        = gc_decode(q.sh);

    always_comb begin
        d        = q;
        wr_stb   = 1'b0;
        rd_stb   = 1'b0;
        gc_rst   = 1'b0;
        ptr_load = 1'b0;
        ptr_adv  = 1'b0;
        ptr_clr  = 1'b0;
        if (q.shut) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (stop_det) begin
            d.st     = ST_IDLE;
            d.oe     = 1'b0;
            d.bitcnt = '0;
        end else if (start_det) begin
            d.st     = ST_DEVADR;
            d.oe     = 1'b0;
            d.bitcnt = '0;
        end else begin
            unique case (q.st)
                ST_DEVADR, ST_PTR, ST_WDATA, ST_GCCMD: begin
                    if (scl_rise && q.bitcnt < BITS_PER_BYTE) begin
                        d.sh     = {q.sh[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (byte_done) begin
                        d.bitcnt = '0;
                        d.st     = ST_ACK;
                        d.oe     = 1'b1;
                        unique case (q.st)
                            ST_DEVADR: begin
                                if (q.sh[7:1] == {DEV_PREFIX, q.pbit}) begin
                                    d.after = q.sh[0] ? ST_RDATA : ST_PTR;
                                end else if (q.sh == GC_BYTE) begin
                                    d.after = ST_GCCMD;
                                end else begin
                                    d.oe = 1'b0;
                                    d.st = ST_SKIP;
                                end
                            end
                            ST_PTR: begin
                                ptr_load = 1'b1;
                                d.after  = ST_WDATA;
                            end
                            ST_WDATA: begin
                                wr_stb  = 1'b1;
                                ptr_adv = 1'b1;
                                d.after = ST_WDATA;
                                if (ptr == SHDN_ADDR && q.sh[SHDN_BIT]) d.pend = 1'b1;
                            end
                            default: begin
                                d.after = ST_SKIP;
                                if (gk == GC_IGNORE) begin
                                    d.oe = 1'b0;
                                    d.st = ST_SKIP;
                                end else begin
                                    d.pbit = addr_pin_i;
                                    if (gk == GC_LATCH_RST) begin
                                        gc_rst  = 1'b1;
                                        ptr_clr = 1'b1;
                                    end
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = q.after;
                        if (q.pend) begin
                            d.shut = 1'b1;
                            d.st   = ST_IDLE;
                        end else if (q.after == ST_RDATA) begin
                            rd_stb   = 1'b1;
                            d.sh     = rdata;
                            d.oe     = ~rdata[7];
                            d.bitcnt = '0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.bitcnt == 4'd7) begin
                            d.oe     = 1'b0;
                            d.bitcnt = '0;
                            d.st     = ST_RACK;
                        end else begin
                            d.bitcnt = q.bitcnt + 4'd1;
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.oe     = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ptr_adv = 1'b1;
                        d.st    = sda_s ? ST_IDLE : ST_RNEXT;
                    end
                end
                ST_RNEXT: begin
                    if (scl_fall) begin
                        rd_stb   = 1'b1;
                        d.sh     = rdata;
                        d.oe     = ~rdata[7];
                        d.bitcnt = '0;
                        d.st     = ST_RDATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.after  <= ST_IDLE;
            q.pbit   <= addr_pin_i;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign shreg  = q.sh;

    a_r1_drive_window: assert property (@(posedge clk) disable iff (rst)
        q.oe |-> (q.st inside {ST_ACK, ST_RDATA}));
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_stb, rd_stb, gc_rst}));
    a_r7_nack_release: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_RACK && scl_rise && sda_s && !q.shut) |=> (q.st == ST_IDLE && !q.oe));
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        q.shut |-> (!q.oe && !wr_stb && !rd_stb));
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        q.shut |=> q.shut);
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> q.st == ST_IDLE);

endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
    import i2c_rp_pkg::*;
#(
    parameter int unsigned                ADDR_W      = 8,
    parameter int unsigned                N_RANGES    = 2,
    parameter logic [ADDR_W-1:0]          LAST_ADDR   = 8'h12,
    parameter logic [N_RANGES*ADDR_W-1:0] RANGE_LO    = {8'h10, 8'h00},
    parameter logic [N_RANGES*ADDR_W-1:0] RANGE_HI    = {8'h12, 8'h04},
    parameter logic [5:0]                 DEV_PREFIX  = 6'b010000,
    parameter logic [ADDR_W-1:0]          SHDN_ADDR   = 8'h04,
    parameter int unsigned                SHDN_BIT    = 6,
    parameter int unsigned                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              addr_pin_i,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_wr_o,
    output logic [7:0]        reg_wdata_o,
    output logic              reg_rd_o,
    input  logic [7:0]        reg_rdata_i,
    output logic              gc_reset_o
);
    logic scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic ptr_load, ptr_adv, ptr_clr;
    logic [7:0] shreg;
    logic [ADDR_W-1:0] ptr;

    i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
    );

    i2c_rp_ptr #(
        .ADDR_W(ADDR_W), .N_RANGES(N_RANGES), .LAST_ADDR(LAST_ADDR),
        .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI)
    ) u_ptr (
        .clk(clk), .rst(rst), .clr(ptr_clr), .load(ptr_load),
        .load_val(shreg[ADDR_W-1:0]), .adv(ptr_adv), .ptr(ptr)
    );

    i2c_rp_fsm #(
        .ADDR_W(ADDR_W), .DEV_PREFIX(DEV_PREFIX),
        .SHDN_ADDR(SHDN_ADDR), .SHDN_BIT(SHDN_BIT)
    ) u_fsm (
        .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .addr_pin_i(addr_pin_i), .ptr(ptr), .rdata(reg_rdata_i),
        .sda_oe(sda_oe_o), .wr_stb(reg_wr_o), .rd_stb(reg_rd_o),
        .gc_rst(gc_reset_o), .ptr_load(ptr_load), .ptr_adv(ptr_adv),
        .ptr_clr(ptr_clr), .shreg(shreg)
    );

    assign reg_addr_o  = ptr;
    assign reg_wdata_o = shreg;

    a_r11_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe_o && !reg_wr_o && !gc_reset_o && ptr == '0));

endmodule

// File: tb/i2c_regport_slave_tb.sv
module i2c_regport_slave_tb_top;
    localparam int   HQ = 8;
    localparam int   HH = 16;
    localparam logic [7:0] SHDN_A = 8'h04;
    localparam logic [7:0] LAST_A = 8'h12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1, pin = 1'b0;
    logic sda_oe, wr, rd, gcr;
    logic [7:0] raddr, wdata, rdata;
    wire  sda_bus = sda_m & ~sda_oe;

    logic [7:0] mem     [0:255];
    logic [7:0] exp_mem [0:255];
    assign rdata = mem[raddr];

    i2c_regport_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .addr_pin_i(pin), .reg_addr_o(raddr), .reg_wr_o(wr), .reg_wdata_o(wdata),
        .reg_rd_o(rd), .reg_rdata_i(rdata), .gc_reset_o(gcr)
    );

    int wr_cnt = 0, gcr_pulses = 0, gcr_cycles = 0, cyc = 0;
    logic [7:0] last_wa = '0, last_wd = '0;
    logic gcr_d = 1'b0;
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (wr) begin
            mem[raddr] = wdata;
            wr_cnt     = wr_cnt + 1;
            last_wa    = raddr;
            last_wd    = wdata;
        end
        if (gcr) gcr_cycles = gcr_cycles + 1;
        if (gcr && !gcr_d) gcr_pulses = gcr_pulses + 1;
        gcr_d = gcr;
    end

    int checks = 0, errors = 0;
    logic [6:0] dev_cur = 7'h20;
    logic [7:0] cur_ptr = 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] next_p(input logic [7:0] p);
        if ((p <= 8'h04) || (p >= 8'h10 && p <= LAST_A))
            return (p == LAST_A) ? 8'h00 : p + 8'h01;
        return p;
    endfunction

    task automatic w(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic start_c();
        sda_m = 1'b0; w(HQ); scl_m = 1'b0; w(HQ);
    endtask
    task automatic rstart_c();
        sda_m = 1'b1; w(HQ); scl_m = 1'b1; w(HQ); sda_m = 1'b0; w(HQ); scl_m = 1'b0; w(HQ);
    endtask
    task automatic stop_c();
        sda_m = 1'b0; w(HQ); scl_m = 1'b1; w(HQ); sda_m = 1'b1; w(HQ);
    endtask
    task automatic bit_out(input logic b);
        sda_m = b; w(HQ); scl_m = 1'b1; w(HH); scl_m = 1'b0; w(HQ);
    endtask
    task automatic bit_in(output logic b);
        sda_m = 1'b1; w(HQ); scl_m = 1'b1; w(HH/2); b = sda_bus; w(HH/2); scl_m = 1'b0; w(HQ);
    endtask
    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        ack = ~b;
    endtask
    task automatic recv_byte(input logic nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            bit_in(b);
            v[i] = b;
        end
        bit_out(nack);
    endtask

    task automatic wburst(input logic [7:0] a, input int n, input string tag);
        logic ack;
        logic [7:0] p, d;
        int c0;
        start_c();
        send_byte({dev_cur, 1'b0}, ack); chk(ack, "R1", ack, 1);
        send_byte(a, ack);               chk(ack, "R2", ack, 1);
        p = a;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            if (p == SHDN_A) d[6] = 1'b0;
            c0 = wr_cnt;
            send_byte(d, ack);
            chk(ack && wr_cnt == c0 + 1 && last_wa == p && last_wd == d, tag,
                {last_wa, last_wd}, {p, d});
            exp_mem[p] = d;
            p = next_p(p);
        end
        cur_ptr = p;
        stop_c();
    endtask

    task automatic rburst(input logic [7:0] a, input bit set_ptr, input int n, input string tag);
        logic ack, b;
        logic [7:0] p, d;
        start_c();
        if (set_ptr) begin
            send_byte({dev_cur, 1'b0}, ack); chk(ack, "R1", ack, 1);
            send_byte(a, ack);               chk(ack, "R2", ack, 1);
            rstart_c();
            p = a;
        end else begin
            p = cur_ptr;
        end
        send_byte({dev_cur, 1'b1}, ack); chk(ack, "R1", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, d);
            chk(d == exp_mem[p], tag, d, exp_mem[p]);
            p = next_p(p);
        end
        cur_ptr = p;
        for (int i = 0; i < 9; i++) begin
            bit_in(b);
            chk(b == 1'b1, "R7", b, 1);
        end
        stop_c();
    endtask

    task automatic probe(input logic [7:0] v, input logic exp_ack, input string tag);
        logic ack;
        start_c();
        send_byte(v, ack);
        chk(ack == exp_ack, tag, ack, exp_ack);
        stop_c();
    endtask

    initial begin : watchdog
        wait (cyc > 190000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic ack;
        int c0;
        void'($urandom(32'h1C2B));
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'((i * 37) ^ 8'h5A);
            exp_mem[i] = 8'((i * 37) ^ 8'h5A);
        end
        w(10);
        rst = 1'b0;
        w(5);
        // R11: reset state
        chk(!sda_oe && !wr && !rd && !gcr, "R11", {sda_oe, wr, rd, gcr}, 0);
        rburst(8'h00, 1'b0, 1, "R11");

        // R1: foreign address refused
        probe({7'h2D, 1'b0}, 1'b0, "R1");
        probe({7'h21, 1'b0}, 1'b0, "R1");

        // R5: wrap past the last address
        wburst(8'h10, 4, "R5");
        chk(cur_ptr == 8'h01, "R5", cur_ptr, 1);
        rburst(8'h11, 1'b1, 3, "R5");

        // R4: non-incrementing address
        wburst(8'h08, 3, "R4");
        rburst(8'h08, 1'b1, 2, "R4");

        // R3: increment inside low span
        wburst(8'h01, 3, "R3");
        rburst(8'h00, 1'b1, 5, "R3");

        // R6: read from current pointer
        rburst(8'h00, 1'b0, 2, "R6");

        // random bursts
        for (int it = 0; it < 16; it++) begin
            logic [7:0] a;
            int n;
            a = 8'($urandom_range(0, 23));
            n = $urandom_range(1, 4);
            wburst(a, n, "R2");
            rburst(a, 1'b1, n, "R6");
        end

        // R10: repeated start mid data byte discards it
        start_c();
        send_byte({dev_cur, 1'b0}, ack); chk(ack, "R10", ack, 1);
        send_byte(8'h02, ack);           chk(ack, "R10", ack, 1);
        c0 = wr_cnt;
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        rstart_c();
        stop_c();
        chk(wr_cnt == c0, "R10", wr_cnt, c0);
        cur_ptr = 8'h02;
        rburst(8'h00, 1'b0, 1, "R10");
        // R10: stop mid address byte
        start_c();
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
        stop_c();
        probe({dev_cur, 1'b0}, 1'b1, "R10");

        // R8: general call
        pin = 1'b1;
        probe({7'h21, 1'b0}, 1'b0, "R8");
        start_c();
        send_byte(8'h00, ack); chk(ack, "R8", ack, 1);
        send_byte(8'h05, ack); chk(!ack, "R8", ack, 0);
        stop_c();
        probe({7'h21, 1'b0}, 1'b0, "R8");
        start_c();
        send_byte(8'h00, ack); chk(ack, "R8", ack, 1);
        send_byte(8'h04, ack); chk(ack, "R8", ack, 1);
        stop_c();
        chk(gcr_pulses == 0, "R8", gcr_pulses, 0);
        dev_cur = 7'h21;
        probe({7'h21, 1'b0}, 1'b1, "R8");
        probe({7'h20, 1'b0}, 1'b0, "R1");
        wburst(8'h11, 1, "R2");
        start_c();
        send_byte(8'h00, ack); chk(ack, "R8", ack, 1);
        send_byte(8'h06, ack); chk(ack, "R8", ack, 1);
        stop_c();
        chk(gcr_pulses == 1 && gcr_cycles == 1, "R8", gcr_cycles, 1);
        cur_ptr = 8'h00;
        rburst(8'h00, 1'b0, 1, "R8");

        // R9: shutdown
        start_c();
        send_byte({dev_cur, 1'b0}, ack); chk(ack, "R9", ack, 1);
        send_byte(SHDN_A, ack);          chk(ack, "R9", ack, 1);
        send_byte(8'h40, ack);           chk(ack && last_wa == SHDN_A, "R9", last_wa, SHDN_A);
        exp_mem[SHDN_A] = 8'h40;
        stop_c();
        c0 = wr_cnt;
        start_c();
        send_byte({dev_cur, 1'b0}, ack); chk(!ack, "R9", ack, 0);
        send_byte(8'h08, ack);           chk(!ack, "R9", ack, 0);
        send_byte(8'h33, ack);
        stop_c();
        chk(wr_cnt == c0 && !sda_oe, "R9", wr_cnt, c0);
        probe(8'h00, 1'b0, "R9");
        rst = 1'b1; w(4); rst = 1'b0; w(5);
        chk(!sda_oe && !wr && !gcr, "R11", {sda_oe, wr, gcr}, 0);
        cur_ptr = 8'h00;
        rburst(8'h00, 1'b0, 1, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule